// File: doc/BRIEF.md
# 1-Wire Slave ROM Addressing Unit

This unit runs the addressing phase of a 1-Wire slave. A slot engine in front of it turns bus activity into single-cycle events: bus reset detected, master wrote a bit, and master opened a read slot. After every bus reset the unit collects an 8-bit ROM command. It then runs one of four addressing flows against its 64-bit identity: skip, read, match or bitwise search. When addressing succeeds it grants access to the memory function layer.

The identity is built from a parameterised family code and serial number. An 8-bit CRC is computed over them and placed on top. While the unit transmits, it presents the bit it wants to put on the line. In every other state it presents a released line (logic 1), so that several slaves can share the open-drain bus as a wired-AND. A slave that loses a match or a search stays silent until the next bus reset.

Top module: `onewire_rom_unit`

## Requirements
- R1: After `rst_ni` the unit is idle: `mem_en_o`=0, `rom_done_o`=0, `tx_bit_o`=1, and bits written before the first bus reset are ignored.
- R2: A bus reset starts collection of a new 8-bit command. The command is received least significant bit first.
- R3: Command CCh grants access at once. `rom_done_o` pulses for exactly one cycle, in the cycle after the eighth command bit. `mem_en_o` then stays high until the next bus reset.
- R4: Command 33h transmits the 64 identity bits LSB first, one bit per read request: family code in bits 0-7, serial in bits 8-55, CRC in bits 56-63. Access is granted after the 64th bit.
- R5: The CRC uses x^8+x^5+x^4+1 with a zero start, over the family code and then the serial number, LSB first. Running the transmitted CRC through the same register afterwards leaves zero.
- R6: Command 55h compares 64 received bits, LSB first, with the identity. An exact match grants access.
- R7: During 55h, a differing bit sends the unit to idle. There is no grant, and further bits and read requests have no effect until a bus reset.
- R8: Command F0h runs 64 rounds. Each round sends the identity bit, then its complement, then receives one bit. If all 64 received bits agree with the identity, access is granted.
- R9: During F0h, a received bit that differs from the identity bit sends the unit to idle. Later read requests return 1.
- R10: Any other command code sends the unit to idle with no grant.
- R11: A bus reset in any state aborts the current flow, drops `mem_en_o` and restarts command collection.
- R12: `tx_bit_o` is 1 whenever the unit is not in a transmit step. Read requests in receive steps and written bits in transmit steps are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_reset_i | input | 1 | One-cycle pulse: reset/presence sequence seen on the bus |
| rx_valid_i | input | 1 | One-cycle pulse: master wrote a bit |
| rx_bit_i | input | 1 | Value of the written bit, valid with rx_valid_i |
| tx_req_i | input | 1 | One-cycle pulse: master opened a read slot |
| tx_bit_o | output | 1 | Bit to present in the read slot (1 = release) |
| rom_done_o | output | 1 | One-cycle pulse when access is granted |
| mem_en_o | output | 1 | Memory functions enabled, until next bus reset |

## Verification
The assertions assume that the slot engine's events are single-cycle pulses and never coincide: no cycle carries both a written bit and a read request. They also assume that `tx_bit_o` is sampled before the read request that consumes it. The bench drives each event as an isolated one-cycle pulse on the falling clock edge, with idle cycles between events. It reads `tx_bit_o` in the cycle that raises `tx_req_i`. No flow is interrupted except by a bus reset pulse that stands alone.

// File: rtl/onewire_rom_pkg.sv
package onewire_rom_pkg;

  localparam logic [7:0] CMD_READ   = 8'h33;
  localparam logic [7:0] CMD_MATCH  = 8'h55;
  localparam logic [7:0] CMD_SEARCH = 8'hF0;
  localparam logic [7:0] CMD_SKIP   = 8'hCC;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SRCH_B,
    ST_SRCH_C,
    ST_SRCH_W,
    ST_GRANT
  } rom_state_e;

  // one LSB-first step of x^8+x^5+x^4+1 (reflected form)
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc8_step = {1'b0, c[7:1]} ^ (fb ? 8'h8C : 8'h00);
  endfunction

endpackage

// File: rtl/rom_id_crc.sv
module rom_id_crc #(
  parameter int DATA_W = 56
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [7:0]        crc_o
);
  import onewire_rom_pkg::*;

  logic [7:0] stage [DATA_W+1];

  assign stage[0] = 8'h00;

  for (genvar g = 0; g < DATA_W; g++) begin : g_stage
    assign stage[g+1] = crc8_step(stage[g], data_i[g]);
  end

  assign crc_o = stage[DATA_W];

endmodule

// File: rtl/rom_cmd_rx.sv
module rom_cmd_rx #(
  parameter int CMD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             rx_valid_i,
  input  logic             rx_bit_i,
  output logic             cmd_valid_o,
  output logic [CMD_W-1:0] cmd_o
);
  localparam int CNT_W = $clog2(CMD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

  logic [CMD_W-1:0] sr_q;
  logic [CNT_W-1:0] cnt_q;

  // LSB first: new bit enters at the top
  assign cmd_o       = {rx_bit_i, sr_q[CMD_W-1:1]};
  assign cmd_valid_o = en_i && rx_valid_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (en_i && rx_valid_i) begin
      sr_q  <= cmd_o;
      cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  a_r2_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));

  a_r2_count_moves_on_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !(en_i && rx_valid_i)) |=> $stable(cnt_q));

endmodule

// File: rtl/rom_seq.sv
module rom_seq #(
  parameter int ID_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_reset_i,
  input  logic            rx_valid_i,
  input  logic            rx_bit_i,
  input  logic            tx_req_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            cmd_valid_i,
  input  logic [7:0]      cmd_i,
  output logic            cmd_en_o,
  output logic            tx_bit_o,
  output logic            rom_done_o,
  output logic            mem_en_o
);
  import onewire_rom_pkg::*;

  localparam int IDX_W = $clog2(ID_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

  rom_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             id_bit;
  logic             last_bit;

  assign id_bit   = id_i[idx_q];
  assign last_bit = (idx_q == IDX_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (bus_reset_i) begin
        state_q <= ST_CMD;
        idx_q   <= '0;
      end else begin
        unique case (state_q)
          ST_CMD: if (cmd_valid_i) begin
            idx_q <= '0;
            unique case (cmd_i)
              CMD_SKIP:   begin state_q <= ST_GRANT; done_q <= 1'b1; end
              CMD_READ:   state_q <= ST_READ;
              CMD_MATCH:  state_q <= ST_MATCH;
              CMD_SEARCH: state_q <= ST_SRCH_B;
              default:    state_q <= ST_IDLE;
            endcase
          end
          ST_READ: if (tx_req_i) begin
            if (last_bit) begin
              state_q <= ST_GRANT;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          ST_MATCH: if (rx_valid_i) begin
            if (rx_bit_i != id_bit) begin
              state_q <= ST_IDLE;
            end else if (last_bit) begin
              state_q <= ST_GRANT;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          ST_SRCH_B: if (tx_req_i) state_q <= ST_SRCH_C;
          ST_SRCH_C: if (tx_req_i) state_q <= ST_SRCH_W;
          ST_SRCH_W: if (rx_valid_i) begin
            if (rx_bit_i != id_bit) begin
              state_q <= ST_IDLE;
            end else if (last_bit) begin
              state_q <= ST_GRANT;
              done_q  <= 1'b1;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_SRCH_B;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_READ, ST_SRCH_B: tx_bit_o = id_bit;
      ST_SRCH_C:          tx_bit_o = ~id_bit;
      default:            tx_bit_o = 1'b1;
    endcase
  end

  assign cmd_en_o   = (state_q == ST_CMD);
  assign rom_done_o = done_q;
  assign mem_en_o   = (state_q == ST_GRANT);

  a_r3_done_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_done_o |=> !rom_done_o);

  a_r3_done_with_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_done_o |-> mem_en_o);

  a_r12_granted_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> tx_bit_o);

  a_r8_complement_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SRCH_C && $past(state_q) == ST_SRCH_B) |-> (tx_bit_o != $past(tx_bit_o)));

  a_r11_reset_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (!mem_en_o && !rom_done_o));

  a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !bus_reset_i) |=> (state_q == ST_IDLE && !rom_done_o && tx_bit_o));

endmodule

// File: rtl/onewire_rom_unit.sv
module onewire_rom_unit #(
  parameter logic [7:0]  FAMILY = 8'h06,
  parameter logic [47:0] SERIAL = 48'h00A1_5C3E_9B27
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_reset_i,
  input  logic rx_valid_i,
  input  logic rx_bit_i,
  input  logic tx_req_i,
  output logic tx_bit_o,
  output logic rom_done_o,
  output logic mem_en_o
);
  localparam int FAM_W = 8;
  localparam int SER_W = 48;
  localparam int CRC_W = 8;
  localparam int DAT_W = FAM_W + SER_W;
  localparam int ID_W  = DAT_W + CRC_W;

  logic [CRC_W-1:0] crc;
  logic [ID_W-1:0]  id;
  logic             cmd_en;
  logic             cmd_valid;
  logic [7:0]       cmd;

  rom_id_crc #(.DATA_W(DAT_W)) u_crc (
    .data_i ({SERIAL, FAMILY}),
    .crc_o  (crc)
  );

  assign id = {crc, SERIAL, FAMILY};

  rom_cmd_rx #(.CMD_W(8)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (bus_reset_i),
    .en_i        (cmd_en),
    .rx_valid_i  (rx_valid_i),
    .rx_bit_i    (rx_bit_i),
    .cmd_valid_o (cmd_valid),
    .cmd_o       (cmd)
  );

  rom_seq #(.ID_W(ID_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .rx_valid_i  (rx_valid_i),
    .rx_bit_i    (rx_bit_i),
    .tx_req_i    (tx_req_i),
    .id_i        (id),
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .cmd_en_o    (cmd_en),
    .tx_bit_o    (tx_bit_o),
    .rom_done_o  (rom_done_o),
    .mem_en_o    (mem_en_o)
  );

endmodule

// File: tb/onewire_rom_unit_tb.sv
module onewire_rom_unit_tb;

  localparam logic [7:0]  FAM = 8'h06;
  localparam logic [47:0] SER = 48'h00A1_5C3E_9B27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0;
  logic rx_valid = 1'b0;
  logic rx_bit = 1'b0;
  logic tx_req = 1'b0;
  logic tx_bit, rom_done, mem_en;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [63:0] exp_id;

  always #5 clk = ~clk;

  onewire_rom_unit #(.FAMILY(FAM), .SERIAL(SER)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_reset_i (bus_reset),
    .rx_valid_i  (rx_valid),
    .rx_bit_i    (rx_bit),
    .tx_req_i    (tx_req),
    .tx_bit_o    (tx_bit),
    .rom_done_o  (rom_done),
    .mem_en_o    (mem_en)
  );

  // {command, grant expected right after command}
  localparam logic [8:0] VEC [8] = '{
    {8'hCC, 1'b1}, {8'h33, 1'b0}, {8'h55, 1'b0}, {8'hF0, 1'b0},
    {8'h00, 1'b0}, {8'hFF, 1'b0}, {8'h3C, 1'b0}, {8'hC3, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_bus_reset();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_valid = 1'b1; rx_bit = b;
    @(negedge clk); rx_valid = 1'b0; rx_bit = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic read_bit(output logic b);
    @(negedge clk); b = tx_bit; tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  function automatic logic [7:0] ref_crc(input logic [63:0] d, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic mix;
      mix = c[0] ^ d[i];
      c = c >> 1;
      if (mix) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  initial begin
    logic b, c;
    logic [63:0] got;
    int seen;

    exp_id = {8'h00, SER, FAM};
    exp_id[63:56] = ref_crc(exp_id, 56);

    // R1 reset state
    idle(2);
    chk("R1 mem_en in reset", mem_en, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 idle mem_en", mem_en, 0);
    chk("R1 idle done", rom_done, 0);
    chk("R1 idle tx", tx_bit, 1);
    send_byte(8'hCC);
    chk("R1 skip before bus reset ignored", {rom_done, mem_en}, 0);

    // R2 R3 R10 command table
    for (int v = 0; v < 8; v++) begin
      do_bus_reset();
      send_byte(VEC[v][8:1]);
      chk($sformatf("R2 R3 R10 cmd %0h grant pulse", VEC[v][8:1]), rom_done, VEC[v][0]);
      chk($sformatf("R3 R10 cmd %0h mem_en", VEC[v][8:1]), mem_en, VEC[v][0]);
      idle(1);
      chk($sformatf("R3 cmd %0h pulse width", VEC[v][8:1]), rom_done, 0);
      if (VEC[v][0]) chk("R3 mem_en held", mem_en, 1);
      if (VEC[v][8:1] inside {8'h00, 8'hFF, 8'h3C, 8'hC3}) begin
        read_bit(b);
        chk("R10 unknown cmd tx released", b, 1);
      end
    end

    // R4 R5 read ROM
    do_bus_reset();
    send_byte(8'h33);
    for (int i = 0; i < 64; i++) begin
      read_bit(b);
      got[i] = b;
      if (i < 63) begin
        seen = seen + rom_done;
      end
    end
    chk("R4 read identity", got, exp_id);
    chk("R4 grant after 64th bit", {rom_done, mem_en}, 2'b11);
    chk("R5 crc byte", got[63:56], exp_id[63:56]);
    chk("R5 crc residue zero", ref_crc(got, 64), 0);
    chk("R5 family in low byte", got[7:0], FAM);

    // R6 R12 match ROM, read requests ignored
    do_bus_reset();
    send_byte(8'h55);
    read_bit(b);
    chk("R12 tx released in match", b, 1);
    for (int i = 0; i < 64; i++) send_bit(exp_id[i]);
    chk("R6 match grant", {rom_done, mem_en}, 2'b11);

    // R7 match mismatch at bit 40
    do_bus_reset();
    send_byte(8'h55);
    seen = 0;
    for (int i = 0; i < 64; i++) begin
      send_bit(i == 40 ? ~exp_id[i] : exp_id[i]);
      seen = seen + rom_done;
    end
    chk("R7 no grant after mismatch", {seen[0], mem_en}, 0);
    read_bit(b);
    chk("R7 tx released after mismatch", b, 1);
    send_byte(8'hCC);
    chk("R7 later bits ignored", {rom_done, mem_en}, 0);

    // R8 search ROM full pass
    do_bus_reset();
    send_byte(8'hF0);
    seen = 0;
    for (int i = 0; i < 64; i++) begin
      read_bit(b);
      read_bit(c);
      if (b !== exp_id[i] || c !== ~exp_id[i]) seen++;
      send_bit(exp_id[i]);
    end
    chk("R8 search bit/complement errors", seen, 0);
    chk("R8 search grant", {rom_done, mem_en}, 2'b11);

    // R9 search mismatch at bit 5
    do_bus_reset();
    send_byte(8'hF0);
    for (int i = 0; i < 5; i++) begin
      read_bit(b); read_bit(c); send_bit(exp_id[i]);
    end
    read_bit(b); read_bit(c);
    chk("R9 search bit5 pair", {b, c}, {exp_id[5], ~exp_id[5]});
    send_bit(~exp_id[5]);
    read_bit(b); read_bit(c);
    chk("R9 released after drop", {b, c}, 2'b11);
    chk("R9 no grant", mem_en, 0);

    // R11 bus reset mid read and while granted
    do_bus_reset();
    send_byte(8'h33);
    for (int i = 0; i < 10; i++) read_bit(b);
    do_bus_reset();
    chk("R11 tx released after abort", tx_bit, 1);
    send_byte(8'hCC);
    chk("R11 restart grants", {rom_done, mem_en}, 2'b11);
    do_bus_reset();
    chk("R11 grant dropped", mem_en, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule